// File: doc/BRIEF.md
# Serial EEPROM Byte Access and Burst Loader

This controller gives a host access to an external byte-wide EEPROM through four small registers. The host places a 16-bit EEPROM location in the pointer register and, for stores, a byte in the data register. It then sets a request bit in the command register. The controller runs the transfer on a request/acknowledge byte port, then clears the request bit by itself. A single pointer serves both modes. It moves forward by one after every byte transferred, so repeated requests walk through the EEPROM.

A third command bit starts a burst load, which copies EEPROM contents into on-chip memory. The EEPROM holds a stream of six-byte records. Each record gives a 16-bit offset and then a 32-bit word. The controller joins the low 15 bits of the offset to a 9-bit window register to form a 24-bit memory address, and it issues one word write per record. An offset of all ones ends the stream. A burst started before any byte access since reset reads from EEPROM location 0. Otherwise it reads on from wherever the pointer stands.

Top module: `eeprom_burst_ctrl`

## Requirements
- R1: After reset all four registers read 0 (command at register index 0, pointer at 1, data at 2, window at 3), `ee_req` is low and `mem_we` is low.
- R2: Writing command bit 1 fetches the byte at the pointer location into data bits [7:0]. Bit 1 reads 1 until the byte has arrived and then returns to 0 without host action.
- R3: Writing command bit 0 stores data bits [7:0] at the pointer location (`ee_we` high). Bit 0 returns to 0 without host action once the store is acknowledged.
- R4: The 16-bit pointer goes up by one after every acknowledged byte, in single and burst mode alike, and wraps from 0xFFFF to 0x0000.
- R5: When bits 1 and 0 are written together, the fetch is done first and the store follows. The store therefore writes the fetched byte to the next location. A burst requested in the same write runs after both.
- R6: Command bit 3 reads 1 while any request bit is pending. Host writes to any register while it reads 1 are ignored.
- R7: Command bit 2 starts a burst and returns to 0 without host action when the burst ends. A burst started with no byte access since reset reads from EEPROM location 0, whatever the pointer register holds.
- R8: A burst started after a byte access has taken place reads from the current pointer, which is the location after the last byte accessed.
- R9: A burst record is two offset bytes (low byte first) followed by four data bytes (least significant first). Each record produces exactly one `mem_we` pulse carrying the 32-bit word. An offset of 0xFFFF ends the burst and produces no write.
- R10: The burst write address is the window register bits [8:0] joined above offset bits [14:0]. Offset bit 15 has no effect.
- R11: `ee_req` stays high, with `ee_addr`, `ee_we` and `ee_wdata` unchanged, until the cycle `ee_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ee_req | output | 1 | Byte transfer request to the EEPROM |
| ee_we | output | 1 | Transfer is a store (1) or fetch (0) |
| ee_addr | output | 16 | EEPROM byte location |
| ee_wdata | output | 8 | Byte to store |
| ee_ack | input | 1 | Transfer done, one cycle |
| ee_rdata | input | 8 | Fetched byte, valid with `ee_ack` |
| mem_we | output | 1 | On-chip memory word write strobe |
| mem_addr | output | 24 | On-chip memory write address |
| mem_wdata | output | 32 | On-chip memory write word |

## Verification
Two events can coincide: a host register write and a transfer already in flight. In that case the command bit and the pointer must not move. The bench provokes this by writing the pointer and a store request back to back, right behind a fetch request. It then judges the result at the ports: the pointer must equal the fetch location plus one, and the EEPROM model must have recorded no store. A second coincidence, fetch and store requested in one write, is judged by the byte that ends up at the following location.

// File: rtl/eeprom_burst_ctrl.sv
module eeprom_burst_ctrl #(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int OFF_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic              ee_ack,
  input  logic [7:0]        ee_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);
  localparam int BASE_W = MEM_AW - OFF_W;
  localparam int LAST_B = 5;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;
  typedef enum logic [1:0] {OP_RD, OP_WR, OP_BST} op_t;

  st_t               st;
  op_t               op;
  logic              rd_p, wr_p, bs_p, fresh;
  logic [EE_AW-1:0]  cnt;
  logic [7:0]        data_q;
  logic [BASE_W-1:0] base;
  logic [2:0]        bidx;
  logic [15:0]       offs;
  logic [23:0]       dbuf;
  logic              busy;

  assign busy     = rd_p | wr_p | bs_p;
  assign ee_req   = (st == S_XFER);
  assign ee_we    = (op == OP_WR);
  assign ee_addr  = cnt;
  assign ee_wdata = data_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {28'd0, busy, bs_p, rd_p, wr_p};
      2'd1:    reg_rdata = 32'(cnt);
      2'd2:    reg_rdata = {24'd0, data_q};
      default: reg_rdata = 32'(base);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_RD;
      rd_p <= 1'b0; wr_p <= 1'b0; bs_p <= 1'b0; fresh <= 1'b1;
      cnt <= '0; data_q <= '0; base <= '0;
      bidx <= '0; offs <= '0; dbuf <= '0;
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (reg_wr && !busy) begin
        case (reg_addr)
          2'd0: begin
            wr_p <= reg_wdata[0];
            rd_p <= reg_wdata[1];
            bs_p <= reg_wdata[2];
          end
          2'd1:    cnt    <= reg_wdata[EE_AW-1:0];
          2'd2:    data_q <= reg_wdata[7:0];
          default: base   <= reg_wdata[BASE_W-1:0];
        endcase
      end
      case (st)
        S_IDLE: begin
          if (rd_p) begin
            op <= OP_RD; st <= S_XFER;
          end else if (wr_p) begin
            op <= OP_WR; st <= S_XFER;
          end else if (bs_p) begin
            op <= OP_BST; st <= S_XFER; bidx <= '0;
            if (fresh) cnt <= '0;
          end
        end
        S_XFER: begin
          if (ee_ack) begin
            cnt   <= cnt + 1'b1;
            fresh <= 1'b0;
            st    <= S_GAP;
            case (op)
              OP_RD: begin data_q <= ee_rdata; rd_p <= 1'b0; end
              OP_WR: wr_p <= 1'b0;
              default: begin
                bidx <= (bidx == 3'(LAST_B)) ? 3'd0 : bidx + 1'b1;
                case (bidx)
                  3'd0: offs[7:0] <= ee_rdata;
                  3'd1: begin
                    if ({ee_rdata, offs[7:0]} == 16'hFFFF) bs_p <= 1'b0;
                    offs[15:8] <= ee_rdata;
                  end
                  3'd2: dbuf[7:0]   <= ee_rdata;
                  3'd3: dbuf[15:8]  <= ee_rdata;
                  3'd4: dbuf[23:16] <= ee_rdata;
                  default: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= {base, offs[OFF_W-1:0]};
                    mem_wdata <= {ee_rdata, dbuf};
                  end
                endcase
              end
            endcase
          end
        end
        default: st <= (op == OP_BST && bs_p) ? S_XFER : S_IDLE;
      endcase
    end
  end

  assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req |-> busy);
  assert_no_set_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && busy) |=> !$rose(rd_p) && !$rose(wr_p) && !$rose(bs_p));
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack) |=> ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata));
  assert_read_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && ee_we) |-> !rd_p);
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && ee_ack) |=> cnt == $past(cnt) + 1'b1);
  assert_memwe_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> op == OP_BST && $past(ee_ack));
  assert_memaddr_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[MEM_AW-1:OFF_W] == base);
endmodule

// File: tb/tb_eeprom_burst_ctrl.sv
module tb_eeprom_burst_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        ee_req, ee_we, ee_ack = 0, mem_we;
  logic [15:0] ee_addr;
  logic [7:0]  ee_wdata, ee_rdata = 0;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;

  int checks = 0, errors = 0, lat = 1, nstores = 0;
  logic [7:0]  eem [int unsigned];
  logic [23:0] mw_a [$];
  logic [31:0] mw_d [$];

  eeprom_burst_ctrl dut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] dflt(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] rd_model(input logic [15:0] a);
    return eem.exists(a) ? eem[a] : dflt(a);
  endfunction
  function automatic logic [23:0] exp_maddr(input logic [8:0] b, input logic [15:0] o);
    return {b, o[14:0]};
  endfunction

  always @(negedge clk) begin
    if (mem_we) begin mw_a.push_back(mem_addr); mw_d.push_back(mem_wdata); end
    if (ee_ack) begin
      ee_ack = 0; lat = $urandom_range(0, 3);
    end else if (ee_req) begin
      if (lat == 0) begin
        ee_ack = 1;
        if (ee_we) begin eem[ee_addr] = ee_wdata; nstores++; end
        else ee_rdata = rd_model(ee_addr);
      end else lat--;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin @(negedge clk); rd(0, v); n++; end while (v[3] && n < 2000);
    check(n < 2000, "R6 idle timeout", v, 0);
  endtask

  task automatic put_rec(inout logic [15:0] p, input logic [15:0] off, input logic [31:0] w);
    eem[p] = off[7:0]; eem[p+16'd1] = off[15:8];
    for (int i = 0; i < 4; i++) eem[p+16'(2+i)] = w[8*i +: 8];
    p = p + 16'd6;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] p, a;
    logic [7:0]  b;
    int n0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      check(v == 0, "R1 register reset", v, 0);
    end
    check(!ee_req && !mem_we, "R1 idle outputs", {ee_req, mem_we}, 0);

    p = 16'h0000;
    put_rec(p, 16'h1234, 32'hDEADBEEF);
    put_rec(p, 16'h8005, 32'h01020304);
    eem[p] = 8'hFF; eem[p+16'd1] = 8'hFF;
    wr(3, 32'h155);
    wr(1, 32'h0700);
    wr(0, 32'h4);
    wait_idle();
    rd(0, v); check(v[2] == 0, "R7 start bit self-clears", v, 0);
    check(mw_a.size() == 2, "R9 record count", mw_a.size(), 2);
    if (mw_a.size() == 2) begin
      check(mw_a[0] == exp_maddr(9'h155, 16'h1234), "R10 burst addr 0", mw_a[0], exp_maddr(9'h155, 16'h1234));
      check(mw_d[0] == 32'hDEADBEEF, "R9 burst word 0", mw_d[0], 32'hDEADBEEF);
      check(mw_a[1] == exp_maddr(9'h155, 16'h8005), "R10 offset bit 15 ignored", mw_a[1], exp_maddr(9'h155, 16'h8005));
      check(mw_d[1] == 32'h01020304, "R9 burst word 1", mw_d[1], 32'h01020304);
    end
    rd(1, v); check(v == 14, "R7 burst from location 0, R4 pointer after", v, 14);

    for (int i = 0; i < 20; i++) begin
      a = 16'($urandom_range(16'h1000, 16'hFFFF));
      wr(1, 32'(a)); wr(0, 32'h2);
      wait_idle();
      rd(2, v); check(v == 32'(rd_model(a)), "R2 single fetch", v, 32'(rd_model(a)));
      rd(1, v); check(v == 32'(a + 16'd1), "R4 pointer after fetch", v, 32'(a + 16'd1));
    end

    for (int i = 0; i < 20; i++) begin
      a = 16'($urandom_range(16'h1000, 16'hFFFF));
      b = 8'($urandom);
      wr(1, 32'(a)); wr(2, {24'hABCDEF, b}); wr(0, 32'h1);
      wait_idle();
      rd(0, v); check(v[0] == 0, "R3 store bit self-clears", v, 0);
      check(rd_model(a) == b, "R3 single store", rd_model(a), b);
      rd(1, v); check(v == 32'(a + 16'd1), "R4 pointer after store", v, 32'(a + 16'd1));
    end

    a = 16'h0800; b = rd_model(a);
    wr(1, 32'(a)); wr(0, 32'h3);
    wait_idle();
    check(rd_model(a + 16'd1) == b, "R5 fetch before store", rd_model(a + 16'd1), b);
    rd(1, v); check(v == 32'(a + 16'd2), "R5 pointer after pair", v, 32'(a + 16'd2));

    wr(1, 32'hFFFF); wr(0, 32'h2);
    wait_idle();
    rd(1, v); check(v == 0, "R4 pointer wrap", v, 0);
    rd(2, v); check(v == 32'(rd_model(16'hFFFF)), "R2 fetch at top", v, 32'(rd_model(16'hFFFF)));

    a = 16'h0900; n0 = nstores;
    wr(1, 32'(a)); wr(0, 32'h2);
    wr(1, 32'h0123); wr(0, 32'h1);
    wait_idle();
    rd(1, v); check(v == 32'(a + 16'd1), "R6 write while busy ignored", v, 32'(a + 16'd1));
    check(nstores == n0, "R6 store request while busy ignored", nstores - n0, 0);

    p = 16'h2001;
    put_rec(p, 16'h7FFE, 32'hCAFEF00D);
    eem[p] = 8'hFF; eem[p+16'd1] = 8'hFF;
    mw_a.delete(); mw_d.delete();
    wr(3, 32'h0A3);
    wr(1, 32'h2000); wr(0, 32'h2);
    wait_idle();
    wr(0, 32'h4);
    wait_idle();
    check(mw_a.size() == 1, "R8 continued burst record count", mw_a.size(), 1);
    if (mw_a.size() == 1) begin
      check(mw_a[0] == exp_maddr(9'h0A3, 16'h7FFE), "R8 continued burst addr", mw_a[0], exp_maddr(9'h0A3, 16'h7FFE));
      check(mw_d[0] == 32'hCAFEF00D, "R9 continued burst word", mw_d[0], 32'hCAFEF00D);
    end
    rd(1, v); check(v == 32'h2009, "R8 pointer after burst", v, 32'h2009);
    check(!ee_req, "R11 request dropped when idle", ee_req, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule